// File: doc/BRIEF.md
# Staged Parallel Latch Bank on a Host Port Window

This block sits on a simple synchronous host bus and presents a bank of 8-bit latches that drive and sample the many parallel digital lines of a device under test. The host fills a set of shadow latches one byte at a time. None of those bytes reaches the device until the host writes a commit command. The commit copies every shadow byte to the output registers on one clock edge and raises the output enable. A clear command drops the enable and returns every output line to zero.

On the input side, a capture command samples all device lines into read latches on one edge. Those latches keep that snapshot until the next capture, whatever the host reads in between. A mode latch holds eight single-bit control levels for the device. The block decodes only its own address window, which is a parameter matched against the high address bits. Outside that window it changes no state and never asserts its read-valid flag.

Address layout: bits [3:0] are the latch index, bits [5:4] are the group (0 = shadow/output bytes, 1 = captured input bytes, 2 = control, 3 = unused), and the bits above them must equal the window base (default base 0xA with 10 address bits, so the window is 0x280 to 0x2BF). In the control group, index 0 is the mode latch and index 1 is the command port.

Top module: `stage_latch_bank`

## Requirements
- R1: After reset, every output line and the output enable are 0, all eight mode outputs are 0 and `bus_rvalid` is 0.
- R2: A write to shadow byte i (address base + i, i below 14) changes no output line; the outputs hold their value in every cycle without a commit or clear.
- R3: Writing the command port (control index 1) with bit 0 set copies all 14 shadow bytes to `dev_out` on the same edge (byte i on lines 8i+7..8i) and sets `dev_oe` to 1.
- R4: Writing the command port with bit 1 set clears `dev_oe` and drives all of `dev_out` to 0; when bits 0 and 1 are both set, the clear wins. The shadow bytes are kept.
- R5: Writing the command port with bit 2 set samples all 112 `dev_in` lines into the read latches on that edge; the read latches do not change until the next capture.
- R6: A read inside the window returns data with `bus_rvalid` = 1 on the cycle after `bus_rd`: group 0 gives the shadow byte, group 1 the captured byte (lines 8i+7..8i), control index 0 the mode latch.
- R7: An access outside the window changes no state; a read there yields `bus_rvalid` = 0 and `bus_rdata` = 0.
- R8: Writing control index 0 sets the mode outputs from the data bits: bit 0 feedback, bit 1 force-high, bit 2 force-low, bit 3 data level, bit 4 weight assign, bit 5 storage enable, bit 6 bias select, bit 7 learn (1) versus direct (0).
- R9: Inside the window, an unused index (group 0 or 1 index 14 or 15, control index 2 and up, all of group 3) ignores writes and reads back with `bus_rvalid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 10 | Host port address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data belongs to this block |
| dev_in | input | 112 | Device output lines to be captured |
| dev_out | output | 112 | Committed lines driven to the device |
| dev_oe | output | 1 | Output enable for the device lines |
| mode_feedback | output | 1 | Mode bit 0 |
| mode_force_hi | output | 1 | Mode bit 1 |
| mode_force_lo | output | 1 | Mode bit 2 |
| mode_data | output | 1 | Mode bit 3 |
| mode_assign | output | 1 | Mode bit 4 |
| mode_store_en | output | 1 | Mode bit 5 |
| mode_bias_sel | output | 1 | Mode bit 6 |
| mode_learn | output | 1 | Mode bit 7 |

## Verification
A shadow byte that leaks early shows as a change on `dev_out` in the cycle right after the host write, before any commit, and a stale copy shows as a wrong byte on the first commit. A read latch that follows its inputs instead of holding shows as a readback that matches the new `dev_in` rather than the captured snapshot, one cycle after the read strobe. A decoder that ignores the window shows as `bus_rvalid` rising for a foreign address, or as an output enable or shadow byte that changes after a foreign write and is read back on the next in-window access.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic [1:0] {
        GRP_WR   = 2'd0,
        GRP_RD   = 2'd1,
        GRP_CTL  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    localparam int CTL_MODE    = 0;
    localparam int CTL_CMD     = 1;
    localparam int CTL_COUNT   = 2;

    localparam int CMD_COMMIT  = 0;
    localparam int CMD_CLEAR   = 1;
    localparam int CMD_CAPTURE = 2;
endpackage

// File: rtl/lb_addr_decode.sv
module lb_addr_decode
    import lb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BASE   = 10,
    parameter int NUM_WR = 14,
    parameter int NUM_RD = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 in_win,
    output logic [3:0]           idx,
    output logic [NUM_WR-1:0]    wr_sel,
    output logic [NUM_RD-1:0]    rd_sel,
    output logic [CTL_COUNT-1:0] ctl_sel
);
    localparam int IDX_W = 4;
    localparam int GRP_W = 2;
    localparam int WIN_W = ADDR_W - IDX_W - GRP_W;

    grp_e grp;

    assign in_win = (addr[ADDR_W-1 -: WIN_W] == WIN_W'(BASE));
    assign grp    = grp_e'(addr[IDX_W +: GRP_W]);
    assign idx    = addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_WR; i++) begin : g_wr_dec
        assign wr_sel[i] = in_win && (grp == GRP_WR) && (idx == IDX_W'(i));
    end
    for (genvar i = 0; i < NUM_RD; i++) begin : g_rd_dec
        assign rd_sel[i] = in_win && (grp == GRP_RD) && (idx == IDX_W'(i));
    end
    for (genvar i = 0; i < CTL_COUNT; i++) begin : g_ctl_dec
        assign ctl_sel[i] = in_win && (grp == GRP_CTL) && (idx == IDX_W'(i));
    end

    // R9: at most one latch is selected for any address
    a_r9_onehot_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_sel, rd_sel, ctl_sel}));
    // R7: nothing is selected outside the window
    a_r7_no_select_outside: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> ({wr_sel, rd_sel, ctl_sel} == '0));
endmodule

// File: rtl/lb_write_bank.sv
module lb_write_bank #(
    parameter int NUM = 14,
    parameter int W   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [NUM-1:0]        sel,
    input  logic [W-1:0]          wdata,
    input  logic                  commit,
    input  logic                  clear,
    output logic [NUM-1:0][W-1:0] shadow,
    output logic [NUM-1:0][W-1:0] dout,
    output logic                  oe
);
    typedef struct packed {
        logic [NUM-1:0][W-1:0] shadow;
        logic [NUM-1:0][W-1:0] outr;
        logic                  oe;
    } wb_state_t;

    wb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && sel[i]) st_d.shadow[i] = wdata;
        end
        if (clear) begin
            st_d.outr = '0;
            st_d.oe   = 1'b0;
        end else if (commit) begin
            st_d.outr = st_q.shadow;
            st_d.oe   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shadow = st_q.shadow;
    assign dout   = st_q.outr;
    assign oe     = st_q.oe;

    // R2: outputs only move on a commit or clear
    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        (!commit && !clear) |=> ($stable(dout) && $stable(oe)));
    // R4: shadow bytes survive a clear
    a_r4_clear_keeps_shadow: assert property (@(posedge clk) disable iff (rst)
        (clear && !wr_en) |=> $stable(shadow));
endmodule

// File: rtl/lb_read_bank.sv
module lb_read_bank #(
    parameter int NUM = 14,
    parameter int W   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  logic [NUM-1:0][W-1:0] din,
    output logic [NUM-1:0][W-1:0] held
);
    typedef struct packed {
        logic [NUM-1:0][W-1:0] held;
    } rb_state_t;

    rb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) st_d.held = din;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held = st_q.held;

    // R5: the snapshot holds until the next capture
    a_r5_hold_between_captures: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(held));
    // R5: a capture takes the lines present at that edge
    a_r5_capture_takes_input: assert property (@(posedge clk) disable iff (rst)
        capture |=> (held == $past(din)));
endmodule

// File: rtl/stage_latch_bank.sv
module stage_latch_bank
    import lb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BASE   = 10,
    parameter int NUM_WR = 14,
    parameter int NUM_RD = 14,
    parameter int W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    output logic                  bus_rvalid,
    input  logic [NUM_RD*W-1:0]   dev_in,
    output logic [NUM_WR*W-1:0]   dev_out,
    output logic                  dev_oe,
    output logic                  mode_feedback,
    output logic                  mode_force_hi,
    output logic                  mode_force_lo,
    output logic                  mode_data,
    output logic                  mode_assign,
    output logic                  mode_store_en,
    output logic                  mode_bias_sel,
    output logic                  mode_learn
);
    logic                     in_win;
    logic [3:0]               idx;
    logic [NUM_WR-1:0]        wr_sel;
    logic [NUM_RD-1:0]        rd_sel;
    logic [CTL_COUNT-1:0]     ctl_sel;
    logic [NUM_WR-1:0][W-1:0] shadow;
    logic [NUM_WR-1:0][W-1:0] out_bytes;
    logic [NUM_RD-1:0][W-1:0] held;
    logic                     cmd_wr, fire_commit, fire_clear, fire_capture;

    lb_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD)) u_dec (
        .clk(clk), .rst(rst), .addr(bus_addr), .in_win(in_win), .idx(idx),
        .wr_sel(wr_sel), .rd_sel(rd_sel), .ctl_sel(ctl_sel)
    );

    assign cmd_wr       = bus_wr && ctl_sel[CTL_CMD];
    assign fire_commit  = cmd_wr && bus_wdata[CMD_COMMIT];
    assign fire_clear   = cmd_wr && bus_wdata[CMD_CLEAR];
    assign fire_capture = cmd_wr && bus_wdata[CMD_CAPTURE];

    lb_write_bank #(.NUM(NUM_WR), .W(W)) u_wr (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .sel(wr_sel), .wdata(bus_wdata),
        .commit(fire_commit), .clear(fire_clear),
        .shadow(shadow), .dout(out_bytes), .oe(dev_oe)
    );

    lb_read_bank #(.NUM(NUM_RD), .W(W)) u_rd (
        .clk(clk), .rst(rst), .capture(fire_capture), .din(dev_in), .held(held)
    );

    assign dev_out = out_bytes;

    typedef struct packed {
        logic [W-1:0] mode;
        logic [W-1:0] rdata;
        logic         rvalid;
    } top_state_t;

    top_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.rvalid = 1'b0;
        if (bus_wr && ctl_sel[CTL_MODE]) st_d.mode = bus_wdata;
        if (bus_rd) begin
            if (|wr_sel) begin
                st_d.rdata  = shadow[idx];
                st_d.rvalid = 1'b1;
            end else if (|rd_sel) begin
                st_d.rdata  = held[idx];
                st_d.rvalid = 1'b1;
            end else if (ctl_sel[CTL_MODE]) begin
                st_d.rdata  = st_q.mode;
                st_d.rvalid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus_rdata     = st_q.rdata;
    assign bus_rvalid    = st_q.rvalid;
    assign mode_feedback = st_q.mode[0];
    assign mode_force_hi = st_q.mode[1];
    assign mode_force_lo = st_q.mode[2];
    assign mode_data     = st_q.mode[3];
    assign mode_assign   = st_q.mode[4];
    assign mode_store_en = st_q.mode[5];
    assign mode_bias_sel = st_q.mode[6];
    assign mode_learn    = st_q.mode[7];

    // R3: a commit without clear enables the outputs with the shadow image
    a_r3_commit_enables: assert property (@(posedge clk) disable iff (rst)
        (fire_commit && !fire_clear) |=> (dev_oe && dev_out == $past(shadow)));
    // R4: a clear idles every line
    a_r4_clear_idles: assert property (@(posedge clk) disable iff (rst)
        fire_clear |=> (!dev_oe && dev_out == '0));
    // R7: a foreign read never claims the bus
    a_r7_outside_no_valid: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_win) |=> (!bus_rvalid && bus_rdata == '0));
    // R6: valid read data only follows a read strobe
    a_r6_valid_needs_read: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);
endmodule

// File: tb/sim_stage_latch_bank.sv
`timescale 1ns/1ps
module sim_stage_latch_bank;
    localparam int NB = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [9:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         bus_rvalid;
    logic [111:0] dev_in = '0;
    logic [111:0] dev_out;
    logic         dev_oe;
    logic         m_fb, m_hi, m_lo, m_dat, m_asg, m_st, m_bias, m_learn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stage_latch_bank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .dev_in(dev_in), .dev_out(dev_out), .dev_oe(dev_oe),
        .mode_feedback(m_fb), .mode_force_hi(m_hi), .mode_force_lo(m_lo),
        .mode_data(m_dat), .mode_assign(m_asg), .mode_store_en(m_st),
        .mode_bias_sel(m_bias), .mode_learn(m_learn)
    );

    // {is_read, addr, wdata, exp_valid, exp_data}
    localparam logic [27:0] VEC [0:13] = '{
        {1'b0, 10'h280, 8'h11, 1'b0, 8'h00},
        {1'b0, 10'h28D, 8'hD7, 1'b0, 8'h00},
        {1'b0, 10'h2A0, 8'hA5, 1'b0, 8'h00},
        {1'b1, 10'h280, 8'h00, 1'b1, 8'h11},
        {1'b1, 10'h28D, 8'h00, 1'b1, 8'hD7},
        {1'b1, 10'h2A0, 8'h00, 1'b1, 8'hA5},
        {1'b1, 10'h180, 8'h00, 1'b0, 8'h00},
        {1'b0, 10'h180, 8'hFF, 1'b0, 8'h00},
        {1'b1, 10'h280, 8'h00, 1'b1, 8'h11},
        {1'b1, 10'h28E, 8'h00, 1'b0, 8'h00},
        {1'b0, 10'h28F, 8'h33, 1'b0, 8'h00},
        {1'b1, 10'h28F, 8'h00, 1'b0, 8'h00},
        {1'b1, 10'h2A3, 8'h00, 1'b0, 8'h00},
        {1'b1, 10'h2B0, 8'h00, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [111:0] pattern(input logic [7:0] seed);
        logic [111:0] p;
        for (int k = 0; k < NB; k++) p[k*8 +: 8] = seed ^ 8'(k * 8'h13);
        return p;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [111:0] p1, p2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 dev_out", dev_out, 0);
        check("R1 dev_oe", dev_oe, 0);
        check("R1 mode", {m_learn, m_bias, m_st, m_asg, m_dat, m_lo, m_hi, m_fb}, 0);
        check("R1 rvalid", bus_rvalid, 0);

        // Table walk: R6 readback, R7 window, R9 unused slots
        for (int v = 0; v < 14; v++) begin
            if (VEC[v][27]) begin
                bus_read(VEC[v][26:17]);
                check($sformatf("R6_R7_R9 vec %0d valid", v), bus_rvalid, VEC[v][8]);
                check($sformatf("R6_R7_R9 vec %0d data", v), bus_rdata, VEC[v][7:0]);
            end else begin
                bus_write(VEC[v][26:17], VEC[v][16:9]);
            end
        end

        // R2: staged bytes not yet visible
        check("R2 staged out", dev_out, 0);
        check("R2 staged oe", dev_oe, 0);

        // R8: mode bits from 0xA5
        check("R8 mode A5", {m_learn, m_bias, m_st, m_asg, m_dat, m_lo, m_hi, m_fb}, 8'hA5);
        bus_write(10'h2A0, 8'h5A);
        check("R8 mode 5A", {m_learn, m_bias, m_st, m_asg, m_dat, m_lo, m_hi, m_fb}, 8'h5A);
        check("R8 feedback bit0", m_fb, 0);
        check("R8 learn bit7", m_learn, 0);

        // R3: commit releases all bytes together
        bus_write(10'h2A1, 8'h01);
        check("R3 oe", dev_oe, 1);
        check("R3 byte0", dev_out[7:0], 8'h11);
        check("R3 byte13", dev_out[111:104], 8'hD7);
        check("R3 middle", dev_out[103:8], 0);

        // R2: new shadow byte stays hidden until next commit
        bus_write(10'h281, 8'h22);
        check("R2 hidden byte1", dev_out[15:8], 8'h00);
        bus_write(10'h2A1, 8'h01);
        check("R3 second commit byte1", dev_out[15:8], 8'h22);

        // R7: foreign command write has no effect
        bus_write(10'h1A1, 8'h02);
        check("R7 foreign clear oe", dev_oe, 1);
        check("R7 foreign clear out", dev_out[7:0], 8'h11);

        // R4: clear wins over commit, shadow kept
        bus_write(10'h2A1, 8'h03);
        check("R4 oe", dev_oe, 0);
        check("R4 out idle", dev_out, 0);
        bus_read(10'h281);
        check("R4 shadow kept", bus_rdata, 8'h22);
        bus_write(10'h2A1, 8'h01);
        check("R4 recommit", dev_out[15:0], 16'h2211);

        // R5: capture and hold
        p1 = pattern(8'h4C);
        p2 = pattern(8'hB1);
        @(negedge clk);
        dev_in = p1;
        bus_write(10'h2A1, 8'h04);
        dev_in = p2;
        check("R5 capture keeps outputs", dev_oe, 1);
        bus_read(10'h290);
        check("R5 held byte0", bus_rdata, p1[7:0]);
        bus_read(10'h29D);
        check("R5 held byte13", bus_rdata, p1[111:104]);
        check("R5 held valid", bus_rvalid, 1);
        bus_read(10'h295);
        check("R5 held byte5", bus_rdata, p1[47:40]);
        bus_write(10'h2A1, 8'h04);
        bus_read(10'h295);
        check("R5 recapture byte5", bus_rdata, p2[47:40]);
        check("R6 rvalid one cycle", 1'b1, bus_rvalid);
        @(negedge clk);
        check("R6 rvalid drops", bus_rvalid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule